// File: doc/BRIEF.md
# Instruction Fetch Front End with Compressed-Instruction Support

This block sits between a core's program counter and memory. A fetch request carries a virtual address. The block answers it with a 32-bit instruction word, a misaligned-address fault or a translation fault. Word-aligned fetches are served from a small direct-mapped instruction cache when they hit.

On a miss the block sends the address to an external translator. It then reads a full word from the physical address that comes back and fills the cache entry. A fetch on an address with remainder 2 modulo 4 holds a compressed instruction, or the first half of a full one. For such a fetch, each 16-bit half is translated and read on its own, and the cache is never written.

A flush input empties the whole cache in one cycle. Requests use a valid/ready handshake. They are held off while a translation or a memory read is outstanding.

Top module: `fetch_frontend`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `xlat_req_valid` and `mem_req_valid` are 0. The cache holds no valid entry, so even address 0 misses and is translated.
- R2: A word-aligned miss sends the fetch address to the translator and then issues one word read (`mem_word`=1) at the returned physical address. The response word equals the read data.
- R3: A word-aligned fetch that hits answers with `rsp_valid` one cycle after acceptance, with the cached word and no translation or memory request.
- R4: The cache is indexed by address bits [9:2] (256 entries). An entry matches only its own full address. A fetch to an address that shares the index but differs in the upper bits misses and replaces the entry.
- R5: For an address with bits [1:0]=2'b10, the block translates the address and performs one halfword read (`mem_word`=0). If the halfword's bits [1:0] are not 2'b11 (compressed encoding), the response is {16'h0000, halfword}.
- R6: If that first halfword has bits [1:0]=2'b11, the block translates address+2 separately and reads a second halfword. The response is {second, first}.
- R7: A fetch at an address with bits [1:0]=2'b10 never fills the cache. Repeating it translates again.
- R8: An address with bit 0 set answers one cycle after acceptance with `rsp_misalign`=1. No translation is requested.
- R9: A translation fault, on either half, answers with `rsp_xfault`=1 and `rsp_insn`=0. No further memory read is made for that fetch, and the cache is not filled.
- R10: A one-cycle `flush` invalidates every cache entry. Previously cached addresses miss afterwards.
- R11: When `flush` is high in the same cycle as a cache fill, the flush wins and the entry is left invalid. The response of the fetch itself is still the read word.
- R12: `req_ready` is 0 while a translation or memory read is outstanding. While a request is pending, `xlat_vaddr`, `mem_addr` and `mem_word` hold steady until the matching response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate the whole cache |
| req_valid | input | 1 | Fetch request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Virtual fetch address |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_insn | output | 32 | Instruction word (0 on a fault) |
| rsp_misalign | output | 1 | Misaligned-address fault |
| rsp_xfault | output | 1 | Translation fault |
| xlat_req_valid | output | 1 | Translation request pending |
| xlat_vaddr | output | ADDR_W | Address to translate |
| xlat_rsp_valid | input | 1 | Translation result strobe |
| xlat_paddr | input | ADDR_W | Physical address |
| xlat_fault | input | 1 | Translation refused |
| mem_req_valid | output | 1 | Memory read pending |
| mem_addr | output | ADDR_W | Physical read address |
| mem_word | output | 1 | 1 = 32-bit read, 0 = 16-bit read |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rdata | input | 32 | Read data (halfword in bits 15:0) |

## Verification
A flush and a cache fill can land on the same clock edge, since the fill happens when the memory data of a word-aligned miss arrives. The bench provokes this by raising `flush` in the very cycle the modelled memory returns the miss data. It then checks two things: the fetch still returns the read word, and a repeat fetch of that address misses and goes to the translator again, instead of hitting.

// File: rtl/fetch_pkg.sv
// Shared types for the fetch front end.
// Assumes: instruction words are 32 bits, halfwords 16 bits.
package fetch_pkg;

    typedef enum logic [1:0] {
        CLS_WORD = 2'd0,   // address multiple of 4
        CLS_HALF = 2'd1,   // address remainder 2, compressed path
        CLS_BAD  = 2'd2    // misaligned for this configuration
    } addr_cls_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XLAT = 2'd1,
        ST_MEM  = 2'd2
    } fetch_st_t;

    // A halfword whose two low bits are not both set is a compressed encoding.
    function automatic logic is_compressed(input logic [1:0] low_bits);
        return low_bits != 2'b11;
    endfunction

endpackage

// File: rtl/fetch_addr_class.sv
// Classifies a fetch address by its two low bits.
// Assumes: COMP_EN selects whether remainder-2 addresses are legal.
module fetch_addr_class
    import fetch_pkg::*;
#(
    parameter bit COMP_EN = 1'b1
) (
    input  logic [1:0] addr_lo,
    output addr_cls_t  cls
);

    generate
        if (COMP_EN) begin : g_comp
            // Remainder 2 takes the halfword path; odd addresses fault.
            always_comb begin
                if (addr_lo == 2'b00)      cls = CLS_WORD;
                else if (addr_lo == 2'b10) cls = CLS_HALF;
                else                       cls = CLS_BAD;
            end
        end else begin : g_nocomp
            // Without compressed support only word alignment is legal.
            always_comb begin
                cls = (addr_lo == 2'b00) ? CLS_WORD : CLS_BAD;
            end
        end
    endgenerate

endmodule

// File: rtl/fetch_icache.sv
// Direct-mapped instruction cache, one word per entry.
// Tag is the full address with bit 0 forced high, so a cleared tag never hits.
// Assumes: lookup is combinational; fill and flush take effect at the clock edge,
// flush overriding a fill in the same cycle.
module fetch_icache #(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              hit,
    output logic [31:0]       hit_data,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [31:0]       fill_data
);

    localparam int IDX_W = $clog2(ENTRIES);

    logic [ADDR_W-1:0] tag_q  [ENTRIES];
    logic [31:0]       data_q [ENTRIES];

    logic [IDX_W-1:0]  look_idx;
    logic [IDX_W-1:0]  fill_idx;
    logic [ADDR_W-1:0] look_tag;

    // Index and expected tag of the looked-up address.
    always_comb begin
        look_idx = look_addr[IDX_W+1:2];
        fill_idx = fill_addr[IDX_W+1:2];
        look_tag = look_addr | {{(ADDR_W-1){1'b0}}, 1'b1};
    end

    // Hit needs word alignment and a matching stored tag.
    always_comb begin
        hit      = (look_addr[1:0] == 2'b00) && (tag_q[look_idx] == look_tag);
        hit_data = data_q[look_idx];
    end

    // Tag storage: cleared by reset or flush, written on fill.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tag_q[i] <= '0;
            end
        end else if (fill_en) begin
            tag_q[fill_idx] <= fill_addr | {{(ADDR_W-1){1'b0}}, 1'b1};
        end
    end

    // Data storage: written on fill, never reset.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            data_q[fill_idx] <= fill_data;
        end
    end

endmodule

// File: rtl/fetch_seq.sv
// Fetch sequencer: accepts requests, drives translation and memory reads,
// assembles halfword-path instructions and produces the registered response.
// Assumes: translator and memory answer with one-cycle strobes while their
// request is held; only one request is outstanding at a time.
module fetch_seq
    import fetch_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  addr_cls_t         cls,
    input  logic              hit,
    input  logic [31:0]       hit_data,
    output logic              rsp_valid,
    output logic [31:0]       rsp_insn,
    output logic              rsp_misalign,
    output logic              rsp_xfault,
    output logic              xlat_req_valid,
    output logic [ADDR_W-1:0] xlat_vaddr,
    input  logic              xlat_rsp_valid,
    input  logic [ADDR_W-1:0] xlat_paddr,
    input  logic              xlat_fault,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_word,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rdata,
    output logic              fill_en,
    output logic [ADDR_W-1:0] fill_addr,
    output logic [31:0]       fill_data
);

    localparam logic [ADDR_W-1:0] HALF_STEP = ADDR_W'(2);

    fetch_st_t         state_q;
    logic [ADDR_W-1:0] vaddr_q;
    logic [ADDR_W-1:0] paddr_q;
    logic              half_q;
    logic              upper_q;
    logic [15:0]       low_q;

    // Handshake and port drives derived from the state.
    always_comb begin
        req_ready      = (state_q == ST_IDLE);
        xlat_req_valid = (state_q == ST_XLAT);
        xlat_vaddr     = upper_q ? (vaddr_q + HALF_STEP) : vaddr_q;
        mem_req_valid  = (state_q == ST_MEM);
        mem_addr       = paddr_q;
        mem_word       = !half_q;
        fill_en        = (state_q == ST_MEM) && mem_rsp_valid && !half_q;
        fill_addr      = vaddr_q;
        fill_data      = mem_rdata;
    end

    // Main sequencing: accept, translate, read, assemble, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            vaddr_q      <= '0;
            paddr_q      <= '0;
            half_q       <= 1'b0;
            upper_q      <= 1'b0;
            low_q        <= '0;
            rsp_valid    <= 1'b0;
            rsp_insn     <= '0;
            rsp_misalign <= 1'b0;
            rsp_xfault   <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        vaddr_q <= req_addr;
                        half_q  <= (cls == CLS_HALF);
                        upper_q <= 1'b0;
                        if (cls == CLS_BAD) begin
                            rsp_valid    <= 1'b1;
                            rsp_insn     <= '0;
                            rsp_misalign <= 1'b1;
                            rsp_xfault   <= 1'b0;
                        end else if (hit) begin
                            rsp_valid    <= 1'b1;
                            rsp_insn     <= hit_data;
                            rsp_misalign <= 1'b0;
                            rsp_xfault   <= 1'b0;
                        end else begin
                            state_q <= ST_XLAT;
                        end
                    end
                end
                ST_XLAT: begin
                    if (xlat_rsp_valid) begin
                        if (xlat_fault) begin
                            rsp_valid    <= 1'b1;
                            rsp_insn     <= '0;
                            rsp_misalign <= 1'b0;
                            rsp_xfault   <= 1'b1;
                            state_q      <= ST_IDLE;
                        end else begin
                            paddr_q <= xlat_paddr;
                            state_q <= ST_MEM;
                        end
                    end
                end
                ST_MEM: begin
                    if (mem_rsp_valid) begin
                        rsp_misalign <= 1'b0;
                        rsp_xfault   <= 1'b0;
                        if (!half_q) begin
                            rsp_valid <= 1'b1;
                            rsp_insn  <= mem_rdata;
                            state_q   <= ST_IDLE;
                        end else if (upper_q) begin
                            rsp_valid <= 1'b1;
                            rsp_insn  <= {mem_rdata[15:0], low_q};
                            state_q   <= ST_IDLE;
                        end else if (is_compressed(mem_rdata[1:0])) begin
                            rsp_valid <= 1'b1;
                            rsp_insn  <= {16'h0000, mem_rdata[15:0]};
                            state_q   <= ST_IDLE;
                        end else begin
                            low_q   <= mem_rdata[15:0];
                            upper_q <= 1'b1;
                            state_q <= ST_XLAT;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fetch_frontend.sv
// Instruction fetch front end: address classifier, direct-mapped cache and
// fetch sequencer. Only word-aligned misses fill the cache.
// Assumes: external translator and halfword/word memory ports as in fetch_seq.
module fetch_frontend
    import fetch_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 256,
    parameter bit COMP_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [31:0]       rsp_insn,
    output logic              rsp_misalign,
    output logic              rsp_xfault,
    output logic              xlat_req_valid,
    output logic [ADDR_W-1:0] xlat_vaddr,
    input  logic              xlat_rsp_valid,
    input  logic [ADDR_W-1:0] xlat_paddr,
    input  logic              xlat_fault,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_word,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rdata
);

    addr_cls_t         cls;
    logic              hit;
    logic [31:0]       hit_data;
    logic              fill_en;
    logic [ADDR_W-1:0] fill_addr;
    logic [31:0]       fill_data;

    fetch_addr_class #(.COMP_EN(COMP_EN)) u_class (
        .addr_lo (req_addr[1:0]),
        .cls     (cls)
    );

    fetch_icache #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_cache (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .look_addr (req_addr),
        .hit       (hit),
        .hit_data  (hit_data),
        .fill_en   (fill_en),
        .fill_addr (fill_addr),
        .fill_data (fill_data)
    );

    fetch_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_addr       (req_addr),
        .cls            (cls),
        .hit            (hit),
        .hit_data       (hit_data),
        .rsp_valid      (rsp_valid),
        .rsp_insn       (rsp_insn),
        .rsp_misalign   (rsp_misalign),
        .rsp_xfault     (rsp_xfault),
        .xlat_req_valid (xlat_req_valid),
        .xlat_vaddr     (xlat_vaddr),
        .xlat_rsp_valid (xlat_rsp_valid),
        .xlat_paddr     (xlat_paddr),
        .xlat_fault     (xlat_fault),
        .mem_req_valid  (mem_req_valid),
        .mem_addr       (mem_addr),
        .mem_word       (mem_word),
        .mem_rsp_valid  (mem_rsp_valid),
        .mem_rdata      (mem_rdata),
        .fill_en        (fill_en),
        .fill_addr      (fill_addr),
        .fill_data      (fill_data)
    );

endmodule

// File: rtl/fetch_frontend_chk.sv
// Protocol and timing properties of the fetch front end, bound to its ports.
module fetch_frontend_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic              rsp_misalign,
    input logic              rsp_xfault,
    input logic              xlat_req_valid,
    input logic [ADDR_W-1:0] xlat_vaddr,
    input logic              xlat_rsp_valid,
    input logic              xlat_fault,
    input logic              mem_req_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_word,
    input logic              mem_rsp_valid
);

    // R12: no new request is accepted while a port is busy.
    p_busy_not_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (xlat_req_valid || mem_req_valid) |-> !req_ready);

    // R12: a pending translation keeps its address until answered.
    p_xlat_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (xlat_req_valid && !xlat_rsp_valid) |=> (xlat_req_valid && $stable(xlat_vaddr)));

    // R12: a pending memory read keeps address and size until answered.
    p_mem_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_addr) && $stable(mem_word)));

    // R8: an odd address is refused in the next cycle.
    p_misalign_fast_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_addr[0]) |=> (rsp_valid && rsp_misalign));

    // R8: odd addresses never reach the translator.
    p_even_xlat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_req_valid |-> !xlat_vaddr[0]);

    // R9: a translation fault is followed by no memory read.
    p_xfault_no_mem_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xlat_req_valid && xlat_rsp_valid && xlat_fault) |=> (!mem_req_valid && rsp_valid && rsp_xfault));

    // R9: the two fault kinds never appear together.
    p_one_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_misalign && rsp_xfault));

endmodule

bind fetch_frontend fetch_frontend_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_addr       (req_addr),
    .rsp_valid      (rsp_valid),
    .rsp_misalign   (rsp_misalign),
    .rsp_xfault     (rsp_xfault),
    .xlat_req_valid (xlat_req_valid),
    .xlat_vaddr     (xlat_vaddr),
    .xlat_rsp_valid (xlat_rsp_valid),
    .xlat_fault     (xlat_fault),
    .mem_req_valid  (mem_req_valid),
    .mem_addr       (mem_addr),
    .mem_word       (mem_word),
    .mem_rsp_valid  (mem_rsp_valid)
);

// File: tb/test_fetch_frontend.sv
// Directed bench for fetch_frontend with a modelled translator and memory.
module test_fetch_frontend;

    localparam int ADDR_W   = 32;
    localparam int XLAT_LAT = 2;
    localparam int MEM_LAT  = 3;
    localparam logic [31:0] XMASK = 32'h0001_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              flush = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [31:0]       req_addr = '0;
    logic              rsp_valid;
    logic [31:0]       rsp_insn;
    logic              rsp_misalign;
    logic              rsp_xfault;
    logic              xlat_req_valid;
    logic [31:0]       xlat_vaddr;
    logic              xlat_rsp_valid = 1'b0;
    logic [31:0]       xlat_paddr = '0;
    logic              xlat_fault = 1'b0;
    logic              mem_req_valid;
    logic [31:0]       mem_addr;
    logic              mem_word;
    logic              mem_rsp_valid = 1'b0;
    logic [31:0]       mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int xlat_cnt = 0;
    int mem_cnt = 0;
    int word_reads = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    fetch_frontend i_fetch_frontend (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_insn(rsp_insn),
        .rsp_misalign(rsp_misalign), .rsp_xfault(rsp_xfault),
        .xlat_req_valid(xlat_req_valid), .xlat_vaddr(xlat_vaddr),
        .xlat_rsp_valid(xlat_rsp_valid), .xlat_paddr(xlat_paddr), .xlat_fault(xlat_fault),
        .mem_req_valid(mem_req_valid), .mem_addr(mem_addr), .mem_word(mem_word),
        .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata)
    );

    // Memory content: halfword at physical address p; low bits follow p[3:2].
    function automatic logic [15:0] hw(input logic [31:0] p);
        return {p[17:4] ^ 14'h2C71, p[3:2]};
    endfunction

    function automatic logic [31:0] exp_word(input logic [31:0] v);
        logic [31:0] p = v ^ XMASK;
        return {hw(p + 32'd2), hw(p)};
    endfunction

    function automatic logic [31:0] exp_half(input logic [31:0] v);
        logic [15:0] lo = hw(v ^ XMASK);
        if (lo[1:0] != 2'b11) return {16'h0000, lo};
        return {hw((v + 32'd2) ^ XMASK), lo};
    endfunction

    // Translator model: fixed latency, faults on the top address nibble F.
    initial begin : xlat_model
        int n = 0;
        forever begin
            @(negedge clk);
            if (xlat_rsp_valid) begin
                xlat_rsp_valid = 1'b0;
            end else if (xlat_req_valid) begin
                if (n == XLAT_LAT) begin
                    n = 0;
                    xlat_rsp_valid = 1'b1;
                    xlat_paddr = xlat_vaddr ^ XMASK;
                    xlat_fault = (xlat_vaddr[31:28] == 4'hF);
                    xlat_cnt++;
                end else n++;
            end
        end
    end

    // Memory model: fixed latency, word or halfword reads.
    initial begin : mem_model
        int n = 0;
        forever begin
            @(negedge clk);
            if (mem_rsp_valid) begin
                mem_rsp_valid = 1'b0;
            end else if (mem_req_valid) begin
                if (n == MEM_LAT) begin
                    n = 0;
                    mem_rsp_valid = 1'b1;
                    mem_rdata = mem_word ? {hw(mem_addr + 32'd2), hw(mem_addr)}
                                         : {16'h0000, hw(mem_addr)};
                    mem_cnt++;
                    if (mem_word) word_reads++;
                end else n++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One fetch through the handshake; reports latency and readiness while waiting.
    task automatic fetch(input logic [31:0] a, output logic [31:0] insn,
                         output logic mis, output logic xf, output int lat,
                         output bit ready_busy);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid  = 1'b0;
        lat        = 1;
        ready_busy = 1'b0;
        while (!rsp_valid) begin
            if (req_ready) ready_busy = 1'b1;
            @(negedge clk);
            lat++;
        end
        insn = rsp_insn;
        mis  = rsp_misalign;
        xf   = rsp_xfault;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d; logic m, x; int l; bit b; int x0;
        check(req_ready === 1'b1, "R1", "ready after reset", 32'(req_ready), 32'd1);
        check(rsp_valid === 1'b0 && xlat_req_valid === 1'b0 && mem_req_valid === 1'b0,
              "R1", "idle outputs after reset",
              {29'd0, rsp_valid, xlat_req_valid, mem_req_valid}, 32'd0);
        x0 = xlat_cnt;
        fetch(32'h0000_0000, d, m, x, l, b);
        check(xlat_cnt == x0 + 1, "R1", "address 0 misses when empty", 32'(xlat_cnt - x0), 32'd1);
    endtask

    task automatic t_miss_then_hit();
        logic [31:0] d; logic m, x; int l; bit b; int x0, w0;
        x0 = xlat_cnt; w0 = word_reads;
        fetch(32'h0000_0100, d, m, x, l, b);
        check(d == exp_word(32'h100), "R2", "miss word data", d, exp_word(32'h100));
        check(xlat_cnt == x0 + 1 && word_reads == w0 + 1, "R2", "one xlat and one word read",
              32'(xlat_cnt - x0 + word_reads - w0), 32'd2);
        check(!b, "R12", "ready low during miss", 32'(b), 32'd0);
        x0 = xlat_cnt; w0 = mem_cnt;
        fetch(32'h0000_0100, d, m, x, l, b);
        check(d == exp_word(32'h100) && l == 1, "R3", "hit data in one cycle", d, exp_word(32'h100));
        check(xlat_cnt == x0 && mem_cnt == w0, "R3", "hit makes no requests",
              32'(xlat_cnt - x0 + mem_cnt - w0), 32'd0);
    endtask

    task automatic t_alias();
        logic [31:0] d; logic m, x; int l; bit b; int x0;
        x0 = xlat_cnt;
        fetch(32'h0000_0500, d, m, x, l, b);
        check(xlat_cnt == x0 + 1 && d == exp_word(32'h500), "R4", "same index other tag misses",
              d, exp_word(32'h500));
        x0 = xlat_cnt;
        fetch(32'h0000_0100, d, m, x, l, b);
        check(xlat_cnt == x0 + 1, "R4", "replaced entry misses", 32'(xlat_cnt - x0), 32'd1);
        x0 = xlat_cnt;
        fetch(32'h0000_0104, d, m, x, l, b);
        fetch(32'h0000_0104, d, m, x, l, b);
        check(xlat_cnt == x0 + 1 && d == exp_word(32'h104), "R4", "neighbour index hits",
              d, exp_word(32'h104));
    endtask

    task automatic t_half();
        logic [31:0] d; logic m, x; int l; bit b; int x0, w0;
        x0 = xlat_cnt; w0 = word_reads;
        fetch(32'h0000_0102, d, m, x, l, b);
        check(d == exp_half(32'h102) && d[31:16] == 16'h0, "R5", "compressed half", d, exp_half(32'h102));
        check(xlat_cnt == x0 + 1 && word_reads == w0, "R5", "one xlat, halfword read only",
              32'(xlat_cnt - x0), 32'd1);
        x0 = xlat_cnt;
        fetch(32'h0000_010E, d, m, x, l, b);
        check(d == exp_half(32'h10E), "R6", "two halves assembled", d, exp_half(32'h10E));
        check(xlat_cnt == x0 + 2, "R6", "second half translated", 32'(xlat_cnt - x0), 32'd2);
        x0 = xlat_cnt;
        fetch(32'h0000_0102, d, m, x, l, b);
        check(xlat_cnt == x0 + 1, "R7", "half fetch not cached", 32'(xlat_cnt - x0), 32'd1);
    endtask

    task automatic t_misalign();
        logic [31:0] d; logic m, x; int l; bit b; int x0;
        x0 = xlat_cnt;
        fetch(32'h0000_0201, d, m, x, l, b);
        check(m && !x && l == 1, "R8", "odd address fault", {m, x, 30'(l)}, {2'b10, 30'd1});
        fetch(32'h0000_0203, d, m, x, l, b);
        check(m && xlat_cnt == x0, "R8", "no translation on misalign", 32'(xlat_cnt - x0), 32'd0);
    endtask

    task automatic t_xfault();
        logic [31:0] d; logic m, x; int l; bit b; int m0, x0;
        m0 = mem_cnt;
        fetch(32'hF000_0000, d, m, x, l, b);
        check(x && !m && d == 0 && mem_cnt == m0, "R9", "word xlat fault", {m, x, 30'(mem_cnt - m0)}, {2'b01, 30'd0});
        x0 = xlat_cnt;
        fetch(32'hF000_0000, d, m, x, l, b);
        check(xlat_cnt == x0 + 1, "R9", "faulting fetch not cached", 32'(xlat_cnt - x0), 32'd1);
        m0 = mem_cnt;
        fetch(32'hEFFF_FFFE, d, m, x, l, b);
        check(x && d == 0 && mem_cnt == m0 + 1, "R9", "second half xlat fault",
              32'(mem_cnt - m0), 32'd1);
    endtask

    task automatic t_flush();
        logic [31:0] d; logic m, x; int l; bit b; int x0;
        fetch(32'h0000_0400, d, m, x, l, b);
        fetch(32'h0000_0404, d, m, x, l, b);
        x0 = xlat_cnt;
        fetch(32'h0000_0400, d, m, x, l, b);
        check(xlat_cnt == x0, "R10", "hit before flush", 32'(xlat_cnt - x0), 32'd0);
        do_flush();
        fetch(32'h0000_0400, d, m, x, l, b);
        fetch(32'h0000_0404, d, m, x, l, b);
        check(xlat_cnt == x0 + 2 && d == exp_word(32'h404), "R10", "both miss after flush",
              32'(xlat_cnt - x0), 32'd2);
    endtask

    task automatic t_flush_fill();
        logic [31:0] d; logic m, x; int l; bit b; int x0;
        fork
            fetch(32'h0000_0300, d, m, x, l, b);
            begin
                do begin
                    @(negedge clk);
                    #1;
                end while (!(mem_rsp_valid && mem_word));
                flush = 1'b1;
                @(negedge clk);
                flush = 1'b0;
            end
        join
        check(d == exp_word(32'h300), "R11", "fetch data during flush", d, exp_word(32'h300));
        x0 = xlat_cnt;
        fetch(32'h0000_0300, d, m, x, l, b);
        check(xlat_cnt == x0 + 1 && d == exp_word(32'h300), "R11", "flush beats fill",
              32'(xlat_cnt - x0), 32'd1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_miss_then_hit();
        t_alias();
        t_half();
        t_misalign();
        t_xfault();
        t_flush();
        t_flush_fill();
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule